// File: doc/BRIEF.md
# Vector Unpack Write Sequencer

This block turns a stream of packed vector elements, arriving one byte per handshake, into a sequence of 128-bit quadword writes to a local vector memory. Software or an upstream command decoder sets up a job with a one-cycle `start` strobe. The job carries a format code, a destination byte address, a vector count and a row pattern made of two 8-bit fields. `cl_cfg` is the row stride length and `wl_cfg` is the write length. From the format code the block works out how many stream bytes each vector takes. It gathers those bytes and widens every component into its own 32-bit lane by zero-extension. It then writes one quadword per vector. Masking, tag parsing and sign handling belong to neighbouring blocks.

The row pattern picks one of two stepping modes. When `cl_cfg >= wl_cfg`, the block writes `wl_cfg` rows and then jumps over the rows that remain in the stride (skip mode). When `cl_cfg < wl_cfg`, the block writes `wl_cfg` rows per stride, but only the first `cl_cfg` rows of each stride take data from the stream. The other rows are written with zero (fill mode). The remaining vector count can be read at any time on `num_left`.

Both data paths use valid/ready. A byte moves when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high only while the block is still collecting bytes for the current vector, so it stays low while a finished vector waits on write back-pressure. A write completes when `wr_valid` and `wr_ready` are both high. Once `wr_valid` is raised, it stays high with a steady address and steady data until `wr_ready` accepts the write.

Top module: `vup_seq`

## Requirements
- R1: The format code is split as element width code E = `fmt_code[1:0]` and component count minus one C = `fmt_code[3:2]`. For E in 0..2, each vector uses ((32 >> E) × (C + 1)) / 8 stream bytes. For E = 3 with C = 3, each vector uses 2 bytes.
- R2: A format with E = 3 and C other than 3 is invalid. Such a vector takes no stream bytes and is written as an all-zero quadword.
- R3: `num_cfg` = 0 starts a job of 256 vectors, and `wl_cfg` = 0 counts as a write length of 256.
- R4: In skip mode (`cl_cfg >= wl_cfg`), every vector takes stream bytes. Each write adds 16 to the address. After the `wl_cfg`-th write of a row group, the address also moves by (`cl_cfg` − `wl_cfg`) × 16 and the row counter restarts at 0.
- R5: In fill mode (`cl_cfg < wl_cfg`), a vector takes stream bytes only when its row index within the group is below `cl_cfg`. Any other row is written as zero, and the row counter restarts after `wl_cfg` rows. Each write adds 16 to the address.
- R6: The low four bits of `start_addr` are ignored. Write addresses are ADDR_W bits wide (14 for the large memory, 12 for the small one) and wrap modulo 2^ADDR_W.
- R7: `num_left` holds the job's vector count after `start` and drops by exactly one for each accepted write, reaching 0 at the end.
- R8: `busy` rises on an accepted `start`. `busy` falls and `done` pulses for one cycle in the cycle after the last write is accepted. After reset, both are low.
- R9: The stream is little-endian, with the first byte in the lowest bits. For E in 0..2, component i occupies bits [i×w +: w] of the vector's bytes (w = 32 >> E) and goes zero-extended into lane i (`wr_data[32i +: 32]`). Lanes above C are zero. For the 2-byte format, lanes 0..2 take bits [4:0], [9:5] and [14:10], and lane 3 takes bit 15.
- R10: A stalled write holds `wr_valid`, `wr_addr` and `wr_data` steady. `in_ready` is high only while the block is busy and still short of the current vector's bytes. While idle, `in_ready` and `wr_valid` are low.
- R11: A `start` strobe that arrives while `busy` is high is ignored, and the running job continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job start strobe, taken only while idle |
| fmt_code | input | 4 | Element format: [1:0] width code, [3:2] components minus one |
| start_addr | input | ADDR_W | Destination byte address of the first quadword |
| num_cfg | input | CNT_W | Vectors to write, 0 means 256 |
| cl_cfg | input | CNT_W | Row stride length of the pattern |
| wl_cfg | input | CNT_W | Write length of the pattern, 0 means 256 |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Block can take a stream byte |
| in_data | input | 8 | Stream byte |
| wr_valid | output | 1 | Quadword write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Quadword write byte address |
| wr_data | output | 128 | Quadword write data, four 32-bit lanes |
| num_left | output | CNT_W+1 | Vectors still to be written |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The bench aims at the row-group boundary. A design that mishandled it would miss the skip jump or add it in fill mode, which shifts every later address, or would keep taking stream bytes on fill rows, which desynchronises the stream. Other cases covered are the 256-vector and 256-row encodings of zero, the 5-bit packed format and the invalid width code, an unaligned start address that wraps past the top of memory, and a second `start` in the middle of a job. A wrong zero-count decode ends the job early. A wrong lane layout corrupts `wr_data`. A design that restarts on the second strobe changes the address sequence in the middle of the job. Random ready and valid gaps on both ports check that a stalled write never changes and that no byte is taken while a vector waits.

// File: rtl/vup_pkg.sv
package vup_pkg;
  localparam int QW_BYTES = 16;
  localparam int LANES    = 4;
  localparam int LANE_W   = 32;

  typedef enum logic [1:0] {
    ELEM_32     = 2'd0,
    ELEM_16     = 2'd1,
    ELEM_8      = 2'd2,
    ELEM_PACKED = 2'd3
  } elem_w_e;

  typedef struct packed {
    logic [1:0] comps_m1;
    elem_w_e    ew;
  } fmt_t;

  // stream bytes taken by one vector of the given format
  function automatic logic [4:0] fmt_bytes(input fmt_t f);
    logic [4:0] n;
    n = {3'b000, f.comps_m1} + 5'd1;
    case (f.ew)
      ELEM_32:     return 5'(n << 2);
      ELEM_16:     return 5'(n << 1);
      ELEM_8:      return n;
      default:     return (f.comps_m1 == 2'd3) ? 5'd2 : 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/vup_byte_gather.sv
module vup_byte_gather #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               push,
  input  logic [7:0]         din,
  input  logic               drain,
  output logic [DEPTH*8-1:0] bytes,
  output logic [CW-1:0]      count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear || drain) begin
      count <= '0;
    end else if (push && (count < CW'(DEPTH))) begin
      count <= count + 1'b1;
    end
  end

  // one register per byte slot, loaded when the fill pointer reaches it
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bytes[s*8 +: 8] <= 8'h00;
      end else if (push && !clear && !drain && (count == CW'(s))) begin
        bytes[s*8 +: 8] <= din;
      end
    end
  end
endmodule

// File: rtl/vup_lane_widen.sv
module vup_lane_widen
  import vup_pkg::*;
(
  input  fmt_t                          fmt,
  input  logic [QW_BYTES*8-1:0]         raw,
  output logic [LANES*LANE_W-1:0]       quad
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] lane;
    always_comb begin
      lane = '0;
      if (2'(i) <= fmt.comps_m1) begin
        case (fmt.ew)
          ELEM_32: lane = raw[i*32 +: 32];
          ELEM_16: lane = {16'h0000, raw[i*16 +: 16]};
          ELEM_8:  lane = {24'h000000, raw[i*8 +: 8]};
          default: begin
            if (fmt.comps_m1 == 2'd3) begin
              if (i == LANES - 1) lane = {31'h0, raw[15]};
              else                lane = {27'h0, raw[i*5 +: 5]};
            end
          end
        endcase
      end
    end
    assign quad[i*LANE_W +: LANE_W] = lane;
  end
endmodule

// File: rtl/vup_walk.sv
module vup_walk #(
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  num_req,
  input  logic [CNT_W-1:0]  cl,
  input  logic [CNT_W-1:0]  wl,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W:0]    left,
  output logic              busy,
  output logic              done,
  output logic              consume,
  output logic              accept
);
  localparam int CYC_W = CNT_W + 1;
  localparam logic [CYC_W-1:0]  FULL  = CYC_W'(1) << CNT_W;
  localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'(15);

  logic [CNT_W-1:0]  cl_q;
  logic [CYC_W-1:0]  wl_q, cnt_q;
  logic              skip_q;
  logic [CYC_W-1:0]  wl_eff, cnt_inc, gap;
  logic              row_end;
  logic [ADDR_W-1:0] jump, addr_nxt;

  assign accept  = start && !busy;
  assign wl_eff  = (wl == '0) ? FULL : CYC_W'(wl);
  assign cnt_inc = cnt_q + 1'b1;
  assign row_end = (cnt_inc == wl_q);
  assign gap     = CYC_W'(cl_q) - wl_q;
  assign jump    = (skip_q && row_end) ? (ADDR_W'(gap) << 4) : '0;
  assign addr_nxt = (addr + ADDR_W'(16) + jump) & ALIGN;
  assign consume = skip_q || (cnt_q < CYC_W'(cl_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cl_q   <= '0;
      wl_q   <= '0;
      cnt_q  <= '0;
      skip_q <= 1'b0;
      addr   <= '0;
      left   <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        cl_q   <= cl;
        wl_q   <= wl_eff;
        skip_q <= (CYC_W'(cl) >= wl_eff);
        cnt_q  <= '0;
        addr   <= base_addr & ALIGN;
        left   <= (num_req == '0) ? FULL : CYC_W'(num_req);
        busy   <= 1'b1;
      end else if (busy && step) begin
        left  <= left - 1'b1;
        cnt_q <= row_end ? '0 : cnt_inc;
        addr  <= addr_nxt;
        if (left == CYC_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vup_seq.sv
module vup_seq
  import vup_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        fmt_code,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  num_cfg,
  input  logic [CNT_W-1:0]  cl_cfg,
  input  logic [CNT_W-1:0]  wl_cfg,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [127:0]      wr_data,
  output logic [CNT_W:0]    num_left,
  output logic              busy,
  output logic              done
);
  localparam int BCW = $clog2(QW_BYTES + 1);

  fmt_t                  fmt_q;
  logic [4:0]            vsize;
  logic [BCW-1:0]        have;
  logic [QW_BYTES*8-1:0] raw;
  logic [127:0]          widened;
  logic                  consume, accept, have_all, fire;

  always_ff @(posedge clk) begin
    if (!rst_n)      fmt_q <= fmt_t'(4'h0);
    else if (accept) fmt_q <= fmt_t'(fmt_code);
  end

  assign vsize    = fmt_bytes(fmt_q);
  assign have_all = (5'(have) >= vsize);
  assign wr_valid = busy && (!consume || have_all);
  assign in_ready = busy && consume && !have_all;
  assign fire     = wr_valid && wr_ready;
  assign wr_data  = consume ? widened : '0;

  vup_walk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(start_addr),
    .num_req(num_cfg), .cl(cl_cfg), .wl(wl_cfg), .step(fire),
    .addr(wr_addr), .left(num_left), .busy(busy), .done(done),
    .consume(consume), .accept(accept)
  );

  vup_byte_gather #(.DEPTH(QW_BYTES), .CW(BCW)) u_gather (
    .clk(clk), .rst_n(rst_n), .clear(accept), .push(in_valid && in_ready),
    .din(in_data), .drain(fire && consume), .bytes(raw), .count(have)
  );

  vup_lane_widen u_widen (.fmt(fmt_q), .raw(raw), .quad(widened));
endmodule

// File: rtl/vup_seq_chk.sv
module vup_seq_chk #(
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              in_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [127:0]      wr_data,
  input logic [CNT_W:0]    num_left,
  input logic              busy,
  input logic              done
);
  // R6
  wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[3:0] == 4'h0));

  // R7
  num_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (num_left == $past(num_left) - 1'b1));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && num_left == '0));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !wr_valid));

  // R11
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind vup_seq vup_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .num_left(num_left), .busy(busy), .done(done)
);

// File: tb/sim_vup_seq.sv
module sim_vup_seq;
  localparam int AW = 14;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    fmt_code = '0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] num_cfg = '0, cl_cfg = '0, wl_cfg = '0;
  logic          in_valid = 1'b0, wr_ready = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_ready, wr_valid, busy, done;
  logic [AW-1:0] wr_addr;
  logic [127:0]  wr_data;
  logic [CW:0]   num_left;

  always #2 clk = ~clk;

  vup_seq #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt_code(fmt_code),
    .start_addr(start_addr), .num_cfg(num_cfg), .cl_cfg(cl_cfg), .wl_cfg(wl_cfg),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .num_left(num_left), .busy(busy), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit wd_hit = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input int i, input logic [7:0] salt);
    return 8'(i * 37 + (i >> 5)) ^ salt;
  endfunction

  function automatic int vbytes(input logic [3:0] f);
    if (f[1:0] == 2'd3) return (f[3:2] == 2'd3) ? 2 : 0;
    return ((32 >> f[1:0]) * (f[3:2] + 1)) / 8;
  endfunction

  function automatic logic [127:0] exp_vec(input logic [3:0] f, input int pos,
                                           input logic [7:0] salt);
    logic [127:0] raw, q;
    int w;
    raw = '0;
    q = '0;
    for (int b = 0; b < vbytes(f); b++) raw[b*8 +: 8] = byte_at(pos + b, salt);
    if (f[1:0] == 2'd3) begin
      if (f[3:2] == 2'd3) begin
        q[4:0]     = raw[4:0];
        q[36:32]   = raw[9:5];
        q[68:64]   = raw[14:10];
        q[96]      = raw[15];
      end
    end else begin
      w = 32 >> f[1:0];
      for (int i = 0; i <= int'(f[3:2]); i++)
        for (int j = 0; j < w; j++) q[i*32 + j] = raw[i*w + j];
    end
    return q;
  endfunction

  task automatic run_job(input logic [3:0] f, input logic [AW-1:0] a, input logic [7:0] n,
                         input logic [7:0] cl, input logic [7:0] wl, input bit poke);
    int total, wle, vs, k, pos, fed, cnt, it;
    bit skip, cons, seen, rdy, iv;
    logic [AW-1:0] maddr;
    logic [7:0] salt;
    logic [127:0] expd;
    string rq;
    if (wd_hit) return;
    salt  = 8'($urandom);
    total = (n == 0) ? 256 : int'(n);
    wle   = (wl == 0) ? 256 : int'(wl);
    skip  = (int'(cl) >= wle);
    vs    = vbytes(f);
    maddr = a & ~AW'(15);
    k = 0; pos = 0; fed = 0; cnt = 0; it = 0; seen = 1'b0;
    rq = skip ? "R4" : "R5";
    @(negedge clk);
    fmt_code = f; start_addr = a; num_cfg = n; cl_cfg = cl; wl_cfg = wl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R7: count loaded on start, 0 decodes to 256 (R3)
    check(num_left == 9'(total), "R7", "num_left after start", 128'(num_left), 128'(total));
    forever begin
      start = (poke && it == 3);
      if (poke && it == 3) begin
        // R11: garbage configuration offered while busy
        fmt_code = ~f; start_addr = a + AW'(256); num_cfg = n + 8'd7; cl_cfg = 8'd9; wl_cfg = 8'd1;
      end
      if (done) begin seen = 1'b1; break; end
      rdy = ($urandom % 4) != 0;
      wr_ready = rdy;
      if (wr_valid && rdy) begin
        check(num_left == 9'(total - k), "R7", "num_left before write",
              128'(num_left), 128'(total - k));
        check(wr_addr == maddr, poke ? "R11" : rq, "write address R6",
              128'(wr_addr), 128'(maddr));
        cons = skip || (cnt < int'(cl));
        expd = cons ? exp_vec(f, pos, salt) : '0;
        if (cons) pos += vs;
        check(wr_data == expd, (vs == 0) ? "R2" : (cons ? "R9" : "R5"), "write data",
              wr_data, expd);
        k++;
        cnt++;
        maddr = maddr + AW'(16);
        if (cnt == wle) begin
          if (skip) maddr = maddr + AW'((int'(cl) - wle) * 16);
          cnt = 0;
        end
      end
      iv = ($urandom % 3) != 0;
      in_valid = iv;
      in_data = byte_at(fed, salt);
      if (iv && in_ready) fed++;
      @(negedge clk);
      it++;
      cyc++;
      if (it > 20000 || cyc > 190000) begin
        wd_hit = 1'b1;
        check(1'b0, "R8", "watchdog expired", 128'(k), 128'(total));
        break;
      end
    end
    in_valid = 1'b0;
    wr_ready = 1'b0;
    if (seen) begin
      check(k == total, (total == 256) ? "R3" : "R7", "writes in job", 128'(k), 128'(total));
      check(fed == pos, (vs == 0) ? "R2" : "R1", "stream bytes taken", 128'(fed), 128'(pos));
      check(!busy && num_left == 0, "R8", "idle with zero count at done",
            {busy, 127'(num_left)}, 128'(0));
      @(negedge clk);
      check(!done, "R8", "done lasts one cycle", 128'(done), 128'(0));
      check(!in_ready && !wr_valid, "R10", "ports quiet after job",
            {in_ready, wr_valid}, 128'(0));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // reset state R8 R10 R7
    check(!busy && !done, "R8", "reset busy/done", {busy, done}, 128'(0));
    check(!in_ready && !wr_valid, "R10", "reset handshakes", {in_ready, wr_valid}, 128'(0));
    check(num_left == 0, "R7", "reset count", 128'(num_left), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    run_job(4'hC, 14'h0100, 8'd4, 8'd4, 8'd4, 1'b0);   // R1 R9 full width, skip no gap
    run_job(4'h5, 14'h0200, 8'd7, 8'd4, 8'd2, 1'b0);   // R4 skip with gap
    run_job(4'h2, 14'h0400, 8'd8, 8'd1, 8'd3, 1'b0);   // R5 fill
    run_job(4'hF, 14'h0800, 8'd6, 8'd1, 8'd1, 1'b0);   // R9 5-bit packed
    run_job(4'h3, 14'h0900, 8'd5, 8'd1, 8'd1, 1'b0);   // R2 invalid format
    run_job(4'h7, 14'h0a00, 8'd3, 8'd1, 8'd1, 1'b0);   // R2 invalid format
    run_job(4'h8, 14'h1000, 8'd0, 8'd1, 8'd1, 1'b0);   // R3 num zero means 256
    run_job(4'h6, 14'h2000, 8'd10, 8'd2, 8'd0, 1'b0);  // R3 wl zero means 256
    run_job(4'hC, 14'h3FE7, 8'd5, 8'd1, 8'd1, 1'b0);   // R6 unaligned start and wrap
    run_job(4'hC, 14'h3F00, 8'd6, 8'd9, 8'd2, 1'b0);   // R6 skip jump wraps
    run_job(4'h1, 14'h0300, 8'd4, 8'd0, 8'd2, 1'b0);   // R5 fill with no data rows
    run_job(4'h9, 14'h0500, 8'd9, 8'd2, 8'd2, 1'b1);   // R11 start while busy
    for (int r = 0; r < 25; r++)
      run_job(4'($urandom), AW'($urandom), 8'(1 + $urandom % 24),
              8'($urandom % 6), 8'($urandom % 6), 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule